// File: doc/BRIEF.md
# Two-Port Shared Memory with Contention Arbitration and Mailbox Flags

This block is a 2048-word by 8-bit shared memory with two access ports, called left and right. Each port has its own address, write data, read data, chip enable, write select and output enable. Either port can read or write any word in any clock cycle without waiting for the other. Two processors or engines can use it to exchange buffers.

When both ports select the same word in one cycle and at least one of them writes, the block picks a winner. The losing port sees its busy flag and has its access dropped. A fresh tie goes to the left port. The right port wins only if it already held that word in the cycle before. The loser keeps its request and tries again. Its busy flag stays up for one cycle after the contention ends.

The two highest words act as mailboxes. When the right port writes the top word, the left port's interrupt flag is raised. When the left port writes the word just below it, the right port's flag is raised. The receiving port clears its own flag by reading its mailbox word. A second copy can be built in follower mode. In that mode the busy flags are inputs taken from a leading copy, so that two or more copies side by side form a wider word and make the same arbitration decisions.

Top module: `dpram_mailbox`

## Requirements
- R1: While reset is asserted and after it is released, both read data buses are zero, both valid flags are low, both busy flags are low and both interrupt flags are low.
- R2: A read granted on a port with output enable high returns the stored word on that port's read data one clock later, with the valid flag high. A write granted on either port is visible to reads on both ports from the next cycle on.
- R3: A port whose output enable is low, or whose chip enable is low, shows zero read data and a low valid flag in the following cycle. A write presented with chip enable low leaves the memory unchanged.
- R4: Both ports may read the same word in the same cycle. Neither gets busy, and both receive the stored word.
- R5: When both ports select the same word in one cycle, at least one of them writes, and neither port held that word in the previous cycle, the left port wins. The right busy flag rises in that same cycle, the right access is dropped, and the two busy flags are never high together.
- R6: When the right port was granted an access to a word in the previous cycle and the left port was not, a new conflicting request from the left on that word loses. The left busy flag rises and the left write is dropped.
- R7: A port's busy flag stays high while the contention lasts and for exactly one more cycle after it ends. Its access stays dropped during that extra cycle. After that, busy falls unless a new conflict arises.
- R8: A granted right-port write to address 0x7FF sets the left interrupt flag at the next clock. A granted left-port read of 0x7FF clears it. Other accesses leave it unchanged.
- R9: A granted left-port write to address 0x7FE sets the right interrupt flag at the next clock. A granted right-port read of 0x7FE clears it.
- R10: In follower mode (IS_MASTER = 0), each port's busy input alone decides whether that port's access is dropped, and each busy output mirrors the matching busy input.
- R11: Accesses by the two ports to different words in the same cycle both take effect, and neither port gets busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| l_ce | input | 1 | Left chip enable, active high |
| l_we | input | 1 | Left write select (1 = write, 0 = read) |
| l_oe | input | 1 | Left output enable, active high |
| l_addr | input | AW | Left word address |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left registered read data |
| l_rvalid | output | 1 | Left read data valid |
| l_busy_in | input | 1 | Left busy from a leading copy (follower mode only) |
| l_busy_out | output | 1 | Left busy flag |
| l_int | output | 1 | Left mailbox interrupt flag, active high |
| r_ce | input | 1 | Right chip enable, active high |
| r_we | input | 1 | Right write select (1 = write, 0 = read) |
| r_oe | input | 1 | Right output enable, active high |
| r_addr | input | AW | Right word address |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right registered read data |
| r_rvalid | output | 1 | Right read data valid |
| r_busy_in | input | 1 | Right busy from a leading copy (follower mode only) |
| r_busy_out | output | 1 | Right busy flag |
| r_int | output | 1 | Right mailbox interrupt flag, active high |

## Verification
Contention arbitration and the write of the contested word can land on the same clock edge. The bench provokes this by driving both ports onto one word on a single edge, with different data from each side. It then judges the result from the busy flags sampled before the edge and from a later read-back, which shows which data survived. It repeats this for a fresh tie, where the left port must win, and for a late arrival, where the right port already holds the word. It also runs a follower copy in lockstep. That copy must keep its own data and follow the leader's decision, and the check is repeated once with its busy input forced high to show that the input alone drops the access.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

  // Default geometry of the shared memory.
  localparam int DPM_AW = 11;
  localparam int DPM_DW = 8;

  // Port indices used by the per-side generate loops.
  localparam int SIDE_L = 0;
  localparam int SIDE_R = 1;
  localparam int N_SIDES = 2;

  // Outcome of arbitration for a contested word.
  typedef enum logic {
    WIN_LEFT  = 1'b0,
    WIN_RIGHT = 1'b1
  } win_e;

endpackage

// File: rtl/dpm_arbiter.sv
module dpm_arbiter
  import dpm_pkg::*;
#(
  parameter int AW = DPM_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_ce,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic          r_ce,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  output logic          busy_l,
  output logic          busy_r
);

  // Registered history: who was granted which word last cycle,
  // and who lost a contention last cycle.
  logic          hold_l_q, hold_l_d;
  logic          hold_r_q, hold_r_d;
  logic          l_act_q, l_act_d;
  logic          r_act_q, r_act_d;
  logic [AW-1:0] l_addr_q, l_addr_d;
  logic [AW-1:0] r_addr_q, r_addr_d;

  logic hit;
  logic r_first;
  logic lose_l_now;
  logic lose_r_now;
  win_e winner;

  always_comb begin
    // Same word, both enabled, at least one writer.
    hit = l_ce & r_ce & (l_addr == r_addr) & (l_we | r_we);

    // Right already owned this word and left did not.
    r_first = r_act_q & (r_addr_q == r_addr)
              & ~(l_act_q & (l_addr_q == r_addr));

    // An ongoing contention keeps its winner; a new one goes to the earlier
    // holder, with ties to the left.
    if (hold_r_q) begin
      winner = WIN_LEFT;
    end else if (hold_l_q) begin
      winner = WIN_RIGHT;
    end else if (r_first) begin
      winner = WIN_RIGHT;
    end else begin
      winner = WIN_LEFT;
    end

    lose_l_now = hit & (winner == WIN_RIGHT);
    lose_r_now = hit & (winner == WIN_LEFT);

    busy_l = lose_l_now | hold_l_q;
    busy_r = lose_r_now | hold_r_q;

    hold_l_d = lose_l_now;
    hold_r_d = lose_r_now;

    l_act_d  = l_ce & ~busy_l;
    r_act_d  = r_ce & ~busy_r;
    l_addr_d = l_ce ? l_addr : l_addr_q;
    r_addr_d = r_ce ? r_addr : r_addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l_q <= 1'b0;
      hold_r_q <= 1'b0;
      l_act_q  <= 1'b0;
      r_act_q  <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
    end else begin
      hold_l_q <= hold_l_d;
      hold_r_q <= hold_r_d;
      l_act_q  <= l_act_d;
      r_act_q  <= r_act_d;
      l_addr_q <= l_addr_d;
      r_addr_q <= r_addr_d;
    end
  end

endmodule

// File: rtl/dpm_array.sv
module dpm_array
  import dpm_pkg::*;
#(
  parameter int AW = DPM_AW,
  parameter int DW = DPM_DW
) (
  input  logic          clk,
  input  logic          l_wen,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  input  logic          r_wen,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] l_q,
  output logic [DW-1:0] r_q
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Arbitration guarantees the two write enables never hit one word.
  always_ff @(posedge clk) begin
    if (l_wen) begin
      mem[l_addr] <= l_wdata;
    end
    if (r_wen) begin
      mem[r_addr] <= r_wdata;
    end
  end

  assign l_q = mem[l_addr];
  assign r_q = mem[r_addr];

endmodule

// File: rtl/dpm_rport.sv
module dpm_rport
  import dpm_pkg::*;
#(
  parameter int DW = DPM_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren,
  input  logic          oe,
  input  logic [DW-1:0] q,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);

  logic [DW-1:0] rdata_d;
  logic          rvalid_d;

  always_comb begin
    rvalid_d = ren & oe;
    rdata_d  = rvalid_d ? q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= rdata_d;
      rvalid <= rvalid_d;
    end
  end

endmodule

// File: rtl/dpm_mbox.sv
module dpm_mbox (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_d;

  always_comb begin
    if (set_i) begin
      flag_d = 1'b1;
    end else if (clr_i) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
    end else begin
      flag_o <= flag_d;
    end
  end

endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox
  import dpm_pkg::*;
#(
  parameter int AW        = DPM_AW,
  parameter int DW        = DPM_DW,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_ce,
  input  logic          l_we,
  input  logic          l_oe,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_rvalid,
  input  logic          l_busy_in,
  output logic          l_busy_out,
  output logic          l_int,
  input  logic          r_ce,
  input  logic          r_we,
  input  logic          r_oe,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_rvalid,
  input  logic          r_busy_in,
  output logic          r_busy_out,
  output logic          r_int
);

  // Mailbox words sit at the top of the address space.
  localparam logic [AW-1:0] MBOX_L = {AW{1'b1}};
  localparam logic [AW-1:0] MBOX_R = {{(AW-1){1'b1}}, 1'b0};

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Busy source: own arbiter when leading, the leader's flags when following.
  logic busy_l;
  logic busy_r;

  generate
    if (IS_MASTER) begin : g_lead
      logic unused_busy_in;
      assign unused_busy_in = l_busy_in ^ r_busy_in;

      dpm_arbiter #(.AW(AW)) arb_i (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .l_ce   (l_ce),
        .l_we   (l_we),
        .l_addr (l_addr),
        .r_ce   (r_ce),
        .r_we   (r_we),
        .r_addr (r_addr),
        .busy_l (busy_l),
        .busy_r (busy_r)
      );
    end else begin : g_follow
      assign busy_l = l_busy_in;
      assign busy_r = r_busy_in;
    end
  endgenerate

  assign l_busy_out = busy_l;
  assign r_busy_out = busy_r;

  // Granted accesses.
  logic l_go, r_go;
  logic l_wen, r_wen;
  logic l_ren, r_ren;

  always_comb begin
    l_go  = l_ce & ~busy_l;
    r_go  = r_ce & ~busy_r;
    l_wen = l_go & l_we;
    r_wen = r_go & r_we;
    l_ren = l_go & ~l_we;
    r_ren = r_go & ~r_we;
  end

  // Storage.
  logic [DW-1:0] l_q, r_q;

  dpm_array #(.AW(AW), .DW(DW)) array_i (
    .clk     (clk),
    .l_wen   (l_wen),
    .l_addr  (l_addr),
    .l_wdata (l_wdata),
    .r_wen   (r_wen),
    .r_addr  (r_addr),
    .r_wdata (r_wdata),
    .l_q     (l_q),
    .r_q     (r_q)
  );

  // Per-side read registers and mailbox flags.
  logic [N_SIDES-1:0]         side_ren;
  logic [N_SIDES-1:0]         side_oe;
  logic [N_SIDES-1:0][DW-1:0] side_q;
  logic [N_SIDES-1:0][DW-1:0] side_rdata;
  logic [N_SIDES-1:0]         side_rvalid;
  logic [N_SIDES-1:0]         mb_set;
  logic [N_SIDES-1:0]         mb_clr;
  logic [N_SIDES-1:0]         mb_flag;

  always_comb begin
    side_ren[SIDE_L] = l_ren;
    side_ren[SIDE_R] = r_ren;
    side_oe[SIDE_L]  = l_oe;
    side_oe[SIDE_R]  = r_oe;
    side_q[SIDE_L]   = l_q;
    side_q[SIDE_R]   = r_q;
    // Each flag is set by the opposite side's write to its word
    // and cleared by its own side's read of that word.
    mb_set[SIDE_L]   = r_wen & (r_addr == MBOX_L);
    mb_clr[SIDE_L]   = l_ren & (l_addr == MBOX_L);
    mb_set[SIDE_R]   = l_wen & (l_addr == MBOX_R);
    mb_clr[SIDE_R]   = r_ren & (r_addr == MBOX_R);
  end

  generate
    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
      dpm_rport #(.DW(DW)) rport_i (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .ren    (side_ren[s]),
        .oe     (side_oe[s]),
        .q      (side_q[s]),
        .rdata  (side_rdata[s]),
        .rvalid (side_rvalid[s])
      );

      dpm_mbox mbox_i (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .set_i  (mb_set[s]),
        .clr_i  (mb_clr[s]),
        .flag_o (mb_flag[s])
      );
    end
  endgenerate

  assign l_rdata  = side_rdata[SIDE_L];
  assign r_rdata  = side_rdata[SIDE_R];
  assign l_rvalid = side_rvalid[SIDE_L];
  assign r_rvalid = side_rvalid[SIDE_R];
  assign l_int    = mb_flag[SIDE_L];
  assign r_int    = mb_flag[SIDE_R];

endmodule

// File: rtl/dpm_checker.sv
module dpm_checker #(
  parameter int AW        = 11,
  parameter int DW        = 8,
  parameter bit IS_MASTER = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_ce,
  input logic          l_we,
  input logic          l_oe,
  input logic [AW-1:0] l_addr,
  input logic [DW-1:0] l_rdata,
  input logic          l_rvalid,
  input logic          l_busy_in,
  input logic          l_busy_out,
  input logic          l_int,
  input logic          r_ce,
  input logic          r_we,
  input logic          r_oe,
  input logic [AW-1:0] r_addr,
  input logic [DW-1:0] r_rdata,
  input logic          r_rvalid,
  input logic          r_busy_in,
  input logic          r_busy_out,
  input logic          r_int
);

  localparam logic [AW-1:0] MB_L = {AW{1'b1}};
  localparam logic [AW-1:0] MB_R = {{(AW-1){1'b1}}, 1'b0};

  logic clash;
  logic l_wr_ok, r_wr_ok, l_rd_ok, r_rd_ok;

  assign clash   = l_ce && r_ce && (l_addr == r_addr) && (l_we || r_we);
  assign l_wr_ok = l_ce && l_we && !l_busy_out;
  assign r_wr_ok = r_ce && r_we && !r_busy_out;
  assign l_rd_ok = l_ce && !l_we && !l_busy_out;
  assign r_rd_ok = r_ce && !r_we && !r_busy_out;

  // R3: output enable low gives zero data and no valid next cycle
  assert_oe_low_l_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !l_oe |=> (!l_rvalid && l_rdata == '0));
  assert_oe_low_r_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !r_oe |=> (!r_rvalid && r_rdata == '0));
  assert_ce_low_l_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !l_ce |=> !l_rvalid);
  assert_ce_low_r_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !r_ce |=> !r_rvalid);

  // R2: two valid reads of one word agree
  assert_same_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rvalid && r_rvalid && $past(l_addr) == $past(r_addr)) |-> (l_rdata == r_rdata));

  // R8: left mailbox flag set and clear
  assert_int_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (r_wr_ok && r_addr == MB_L) |=> l_int);
  assert_int_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rd_ok && l_addr == MB_L && !(r_wr_ok && r_addr == MB_L)) |=> !l_int);

  // R9: right mailbox flag set and clear
  assert_int_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr_ok && l_addr == MB_R) |=> r_int);
  assert_int_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (r_rd_ok && r_addr == MB_R && !(l_wr_ok && l_addr == MB_R)) |=> !r_int);

  generate
    if (IS_MASTER) begin : g_lead_chk
      // R5: never both busy
      assert_busy_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_busy_out && r_busy_out));
      // R7: a lost contention keeps busy one more cycle
      assert_busy_hold_r_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clash && r_busy_out) |=> r_busy_out);
      assert_busy_hold_l_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clash && l_busy_out) |=> l_busy_out);
      // R7: a busy with no clash behind it ends next cycle unless a new clash arrives
      assert_busy_release_r_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_busy_out && !clash) |=> (!r_busy_out || clash));
      assert_busy_release_l_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (l_busy_out && !clash) |=> (!l_busy_out || clash));
    end else begin : g_follow_chk
      // R10: busy outputs follow busy inputs
      assert_mirror_l_R10: assert property (@(posedge clk) disable iff (!rst_n)
        l_busy_out == l_busy_in);
      assert_mirror_r_R10: assert property (@(posedge clk) disable iff (!rst_n)
        r_busy_out == r_busy_in);
    end
  endgenerate

endmodule

bind dpram_mailbox dpm_checker #(
  .AW(AW), .DW(DW), .IS_MASTER(IS_MASTER)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .l_ce       (l_ce),
  .l_we       (l_we),
  .l_oe       (l_oe),
  .l_addr     (l_addr),
  .l_rdata    (l_rdata),
  .l_rvalid   (l_rvalid),
  .l_busy_in  (l_busy_in),
  .l_busy_out (l_busy_out),
  .l_int      (l_int),
  .r_ce       (r_ce),
  .r_we       (r_we),
  .r_oe       (r_oe),
  .r_addr     (r_addr),
  .r_rdata    (r_rdata),
  .r_rvalid   (r_rvalid),
  .r_busy_in  (r_busy_in),
  .r_busy_out (r_busy_out),
  .r_int      (r_int)
);

// File: tb/dpram_mailbox_tb_top.sv
module dpram_mailbox_tb_top;

  localparam int AW = 11;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk;
  logic rst_n;

  logic          l_ce, l_we, l_oe, r_ce, r_we, r_oe;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata;

  logic [DW-1:0] m_l_rdata, m_r_rdata, s_l_rdata, s_r_rdata;
  logic          m_l_rvalid, m_r_rvalid, s_l_rvalid, s_r_rvalid;
  logic          m_l_busy, m_r_busy, s_l_busy, s_r_busy;
  logic          m_l_int, m_r_int, s_l_int, s_r_int;

  logic          frc_en, frc_l, frc_r;
  logic          s_l_bin, s_r_bin;
  logic [DW-1:0] s_l_wdata, s_r_wdata;

  int tests;
  int fails;

  assign s_l_bin   = frc_en ? frc_l : m_l_busy;
  assign s_r_bin   = frc_en ? frc_r : m_r_busy;
  assign s_l_wdata = ~l_wdata;
  assign s_r_wdata = ~r_wdata;

  dpram_mailbox #(.AW(AW), .DW(DW), .IS_MASTER(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .l_ce(l_ce), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(m_l_rdata), .l_rvalid(m_l_rvalid), .l_busy_in(1'b0),
    .l_busy_out(m_l_busy), .l_int(m_l_int),
    .r_ce(r_ce), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(m_r_rdata), .r_rvalid(m_r_rvalid), .r_busy_in(1'b0),
    .r_busy_out(m_r_busy), .r_int(m_r_int)
  );

  dpram_mailbox #(.AW(AW), .DW(DW), .IS_MASTER(1'b0)) dut_s (
    .clk(clk), .rst_n(rst_n),
    .l_ce(l_ce), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(s_l_wdata),
    .l_rdata(s_l_rdata), .l_rvalid(s_l_rvalid), .l_busy_in(s_l_bin),
    .l_busy_out(s_l_busy), .l_int(s_l_int),
    .r_ce(r_ce), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(s_r_wdata),
    .r_rdata(s_r_rdata), .r_rvalid(s_r_rvalid), .r_busy_in(s_r_bin),
    .r_busy_out(s_r_busy), .r_int(s_r_int)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  function automatic logic [DW-1:0] pat_a(input int a);
    int v;
    v = a * 37 + 11;
    return v[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] pat_b(input int a);
    int v;
    v = a * 91 + 200;
    return v[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] nb(input logic [DW-1:0] v);
    return ~v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drv_l(input logic ce, input logic we, input logic oe,
                       input int a, input logic [DW-1:0] d);
    l_ce = ce; l_we = we; l_oe = oe; l_addr = a[AW-1:0]; l_wdata = d;
  endtask

  task automatic drv_r(input logic ce, input logic we, input logic oe,
                       input int a, input logic [DW-1:0] d);
    r_ce = ce; r_we = we; r_oe = oe; r_addr = a[AW-1:0]; r_wdata = d;
  endtask

  task automatic idle();
    drv_l(1'b0, 1'b0, 1'b1, 0, '0);
    drv_r(1'b0, 1'b0, 1'b1, 0, '0);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired before the run completed");
    summary();
    $finish;
  end

  initial begin
    tests = 0;
    fails = 0;
    frc_en = 1'b0; frc_l = 1'b0; frc_r = 1'b0;
    idle();
    rst_n = 1'b0;
    tick(); tick(); tick();

    // R1: state while reset is asserted
    chk("R1 l_rdata", m_l_rdata, 0);
    chk("R1 r_rvalid", m_r_rvalid, 0);
    chk("R1 busy", {m_l_busy, m_r_busy}, 0);
    chk("R1 int", {m_l_int, m_r_int, s_l_int, s_r_int}, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1 after release", {m_l_rvalid, m_r_rvalid, m_l_int, m_r_int}, 0);

    // R2: left writes every word, right reads every word
    for (int a = 0; a < DEPTH; a++) begin
      drv_l(1'b1, 1'b1, 1'b1, a, pat_a(a));
      tick();
    end
    idle();
    for (int a = 0; a < DEPTH; a++) begin
      drv_r(1'b1, 1'b0, 1'b1, a, '0);
      tick();
      chk("R2 right read", m_r_rdata, pat_a(a));
      chk("R2 right valid", m_r_rvalid, 1);
      chk("R10 follower right read", s_r_rdata, nb(pat_a(a)));
    end
    idle();
    // R2: right writes every word, left reads every word
    for (int a = 0; a < DEPTH; a++) begin
      drv_r(1'b1, 1'b1, 1'b1, a, pat_b(a));
      tick();
    end
    idle();
    for (int a = 0; a < DEPTH; a++) begin
      drv_l(1'b1, 1'b0, 1'b1, a, '0);
      tick();
      chk("R2 left read", m_l_rdata, pat_b(a));
      chk("R10 follower left read", s_l_rdata, nb(pat_b(a)));
    end
    idle();
    tick();
    chk("R8 R9 flags clear after sweeps", {m_l_int, m_r_int}, 0);

    // R3: output enable low, chip enable low
    drv_l(1'b1, 1'b0, 1'b0, 3, '0);
    tick();
    chk("R3 oe low rdata", m_l_rdata, 0);
    chk("R3 oe low rvalid", m_l_rvalid, 0);
    drv_l(1'b0, 1'b1, 1'b1, 4, 8'hEE);
    tick();
    chk("R3 ce low rvalid", m_l_rvalid, 0);
    drv_l(1'b1, 1'b0, 1'b1, 4, '0);
    tick();
    chk("R3 ce low write ignored", m_l_rdata, pat_b(4));
    idle();
    tick();

    // R4: both read the same word
    drv_l(1'b1, 1'b0, 1'b1, 5, '0);
    drv_r(1'b1, 1'b0, 1'b1, 5, '0);
    #1;
    chk("R4 no busy", {m_l_busy, m_r_busy}, 0);
    tick();
    chk("R4 left data", m_l_rdata, pat_b(5));
    chk("R4 right data", m_r_rdata, pat_b(5));
    idle();
    tick();

    // R11: different words in the same cycle
    drv_l(1'b1, 1'b1, 1'b1, 100, 8'h12);
    drv_r(1'b1, 1'b1, 1'b1, 101, 8'h34);
    #1;
    chk("R11 no busy", {m_l_busy, m_r_busy}, 0);
    tick();
    drv_l(1'b1, 1'b0, 1'b1, 101, '0);
    drv_r(1'b1, 1'b0, 1'b1, 100, '0);
    tick();
    chk("R11 left sees right write", m_l_rdata, 8'h34);
    chk("R11 right sees left write", m_r_rdata, 8'h12);
    idle();
    tick();

    // R5: fresh tie on a write, left wins
    drv_l(1'b1, 1'b1, 1'b1, 10, 8'hA1);
    drv_r(1'b1, 1'b1, 1'b1, 10, 8'hB2);
    #1;
    chk("R5 right busy", m_r_busy, 1);
    chk("R5 left not busy", m_l_busy, 0);
    chk("R10 follower mirrors busy", {s_l_busy, s_r_busy}, 2'b01);
    tick();
    // R7: left leaves, right still blocked for one cycle
    drv_l(1'b0, 1'b0, 1'b1, 0, '0);
    #1;
    chk("R7 busy held one cycle", m_r_busy, 1);
    tick();
    drv_l(1'b1, 1'b0, 1'b1, 10, '0);
    drv_r(1'b0, 1'b0, 1'b1, 0, '0);
    #1;
    chk("R7 busy released", m_r_busy, 0);
    tick();
    chk("R5 R7 right writes dropped", m_l_rdata, 8'hA1);
    chk("R10 follower keeps own data", s_l_rdata, nb(8'hA1));
    drv_l(1'b0, 1'b0, 1'b1, 0, '0);
    drv_r(1'b1, 1'b1, 1'b1, 10, 8'hB2);
    #1;
    chk("R7 retry not busy", m_r_busy, 0);
    tick();
    drv_l(1'b1, 1'b0, 1'b1, 10, '0);
    drv_r(1'b0, 1'b0, 1'b1, 0, '0);
    tick();
    chk("R7 retry lands", m_l_rdata, 8'hB2);
    idle();
    tick();

    // R6: right already holds the word, left arrives late and loses
    drv_r(1'b1, 1'b0, 1'b1, 20, '0);
    tick();
    drv_l(1'b1, 1'b1, 1'b1, 20, 8'hC3);
    #1;
    chk("R6 left busy", m_l_busy, 1);
    chk("R6 right not busy", m_r_busy, 0);
    tick();
    chk("R6 right read old data", m_r_rdata, pat_b(20));
    drv_r(1'b0, 1'b0, 1'b1, 0, '0);
    #1;
    chk("R7 left busy held", m_l_busy, 1);
    tick();
    drv_l(1'b1, 1'b0, 1'b1, 20, '0);
    #1;
    chk("R7 left busy released", m_l_busy, 0);
    tick();
    chk("R6 left write dropped", m_l_rdata, pat_b(20));
    idle();
    tick();

    // R10: forced busy input alone blocks the follower
    frc_en = 1'b1; frc_l = 1'b1; frc_r = 1'b0;
    drv_l(1'b1, 1'b1, 1'b1, 30, 8'h5A);
    #1;
    chk("R10 forced busy mirrored", s_l_busy, 1);
    tick();
    frc_en = 1'b0; frc_l = 1'b0;
    drv_l(1'b1, 1'b0, 1'b1, 30, '0);
    tick();
    chk("R10 leader wrote", m_l_rdata, 8'h5A);
    chk("R10 follower write dropped", s_l_rdata, nb(pat_b(30)));
    idle();
    tick();

    // R8: left mailbox at 0x7FF
    drv_r(1'b1, 1'b1, 1'b1, 'h7FF, 8'h55);
    tick();
    chk("R8 left flag set", m_l_int, 1);
    chk("R8 right flag untouched", m_r_int, 0);
    drv_r(1'b0, 1'b0, 1'b1, 0, '0);
    drv_l(1'b1, 1'b0, 1'b1, 'h7FE, '0);
    tick();
    chk("R8 other read keeps flag", m_l_int, 1);
    drv_l(1'b1, 1'b0, 1'b1, 'h7FF, '0);
    tick();
    chk("R8 left flag cleared", m_l_int, 0);
    chk("R8 mailbox data", m_l_rdata, 8'h55);
    idle();
    tick();

    // R9: right mailbox at 0x7FE
    drv_l(1'b1, 1'b1, 1'b1, 'h7FE, 8'h66);
    tick();
    chk("R9 right flag set", m_r_int, 1);
    chk("R9 left flag untouched", m_l_int, 0);
    drv_l(1'b0, 1'b0, 1'b1, 0, '0);
    drv_r(1'b1, 1'b0, 1'b1, 'h7FE, '0);
    tick();
    chk("R9 right flag cleared", m_r_int, 0);
    chk("R9 mailbox data", m_r_rdata, 8'h66);
    idle();
    tick();

    summary();
    $finish;
  end

endmodule